// File: doc/BRIEF.md
# Parallel Multi-Bit CRC Engine

This block holds a CRC register and folds many message bits into it on each clock. It does not shift one bit per cycle. A single serial step of an MSB-first CRC register is a linear map over GF(2), so it can be written as a constant square matrix. Applying k serial steps is then the k-th power of that matrix. The engine raises the step matrix to the needed powers while the design elaborates. What is left in hardware is only a bank of XOR trees, one per state bit.

On each valid cycle the caller picks one of two update widths. In byte mode, 8 message bits are absorbed. In word mode, a whole state-width word is absorbed. The two modes may be interleaved freely within one message. A synchronous init strobe restarts the register from its preset value. Bit reflection, final XOR and message padding belong to the surrounding logic.

Top module: `crc_par_engine`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `crc_o` equals the preset value `INIT` (default 0xFFFFFFFF).
- R2: One serial step shifts the register left by one position. When the bit shifted out of the top position (bit N-1) was 1, the polynomial `POLY` (default 0x04C11DB7) is XORed into the result. A message holding a single 1 bit therefore produces exactly the value that many serial steps give.
- R3: When `init_i` is high at a rising edge, `crc_o` becomes `INIT` after that edge, whatever `valid_i`, `wide_i` and `data_i` hold.
- R4: When `init_i` and `valid_i` are both low at a rising edge, `crc_o` keeps its value.
- R5: Byte mode is `valid_i`=1, `wide_i`=0, `init_i`=0. After the edge, `crc_o` equals eight serial steps applied to `crc_o` XOR (`data_i[7:0]` placed in bits N-1..N-8, with zeros below).
- R6: Word mode is `valid_i`=1, `wide_i`=1, `init_i`=0. After the edge, `crc_o` equals N serial steps applied to `crc_o` XOR `data_i`.
- R7: In byte mode, bits `data_i[N-1:8]` have no effect on the result.
- R8: Four byte-mode steps, carrying the bytes of a word from its most significant byte down to its least significant byte, leave the same state as one word-mode step on that word.
- R9: The register is linear and has no offset term. A zero state updated with zero data stays zero in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; loads `INIT` |
| init_i | input | 1 | Synchronous restart to `INIT`; takes priority over `valid_i` |
| valid_i | input | 1 | Absorb `data_i` on this edge |
| wide_i | input | 1 | 1 = absorb N bits, 0 = absorb the low byte |
| data_i | input | N | Message word; in byte mode only bits 7..0 are used |
| crc_o | output | N | Current CRC register |

## Verification
A single wrong 1 in a power matrix corrupts one state bit on the first update that uses that mode. The fault then spreads through every later step, so `crc_o` differs from a bit-serial model one cycle after the first affected update. Each update is therefore checked on the very next cycle against a bit-at-a-time model. The byte path and the word path are tested both separately and interleaved, so that a fault in one power shows up at once. A known 9-byte check value, the four-bytes-equal-one-word identity and a single-bit message each tie the matrices to plain serial shifting.

// File: rtl/crc_mat_pkg.sv
package crc_mat_pkg;

  localparam int MAXW = 64;

  typedef logic [MAXW-1:0] vec_t;
  typedef vec_t [MAXW-1:0] mat_t;

  function automatic vec_t low_mask(input int n);
    vec_t m;
    m = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // one MSB-first shift as a matrix: row i lists the inputs feeding bit i
  function automatic mat_t step_matrix(input int n, input vec_t poly);
    mat_t m;
    m = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < n) begin
        if (i > 0) m[i][i-1] = 1'b1;
        m[i][n-1] = m[i][n-1] ^ poly[i];
      end
    end
    return m;
  endfunction

  function automatic mat_t identity(input int n);
    mat_t m;
    m = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < n) m[i][i] = 1'b1;
    end
    return m;
  endfunction

  // GF(2) product: row i of a*b is the XOR of the rows of b selected by row i of a
  function automatic mat_t mat_mul(input int n, input mat_t a, input mat_t b);
    mat_t c;
    vec_t row;
    c = '0;
    for (int i = 0; i < MAXW; i++) begin
      row = '0;
      for (int l = 0; l < MAXW; l++) begin
        if (i < n && l < n && a[i][l]) row = row ^ b[l];
      end
      c[i] = row;
    end
    return c;
  endfunction

  // step matrix raised to the k-th power by square-and-multiply
  function automatic mat_t mat_pow(input int n, input vec_t poly, input int k);
    mat_t r;
    mat_t p;
    r = identity(n);
    p = step_matrix(n, poly);
    for (int b = 0; b < 8; b++) begin
      if (k[b]) r = mat_mul(n, r, p);
      if ((k >> (b + 1)) != 0) p = mat_mul(n, p, p);
    end
    return r;
  endfunction

  function automatic vec_t mat_apply(input int n, input mat_t m, input vec_t v);
    vec_t o;
    o = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < n) o[i] = ^(m[i] & v & low_mask(n));
    end
    return o;
  endfunction

  // bit-serial form of the same update, used by the checker
  function automatic vec_t serial_adv(input int n, input vec_t poly, input vec_t v, input int k);
    vec_t s;
    logic fb;
    s = v & low_mask(n);
    for (int t = 0; t < MAXW; t++) begin
      if (t < k) begin
        fb = s[n-1];
        s  = (s << 1) & low_mask(n);
        if (fb) s = s ^ (poly & low_mask(n));
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/crc_data_align.sv
module crc_data_align #(
  parameter int N      = 32,
  parameter int BYTE_W = 8
) (
  input  logic [N-1:0] state_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] x_byte_o,
  output logic [N-1:0] x_wide_o
);
  localparam int PAD = N - BYTE_W;

  logic [N-1:0] byte_aligned;

  generate
    if (PAD > 0) begin : g_pad
      assign byte_aligned = {data_i[BYTE_W-1:0], {PAD{1'b0}}};
    end else begin : g_nopad
      assign byte_aligned = data_i;
    end
  endgenerate

  assign x_byte_o = state_i ^ byte_aligned;
  assign x_wide_o = state_i ^ data_i;
endmodule

// File: rtl/crc_xor_net.sv
module crc_xor_net
  import crc_mat_pkg::*;
#(
  parameter int          N    = 32,
  parameter logic [N-1:0] POLY = 32'h04C1_1DB7,
  parameter int          K    = 8
) (
  input  logic [N-1:0] x_i,
  output logic [N-1:0] y_o
);
  localparam mat_t MK = mat_pow(N, vec_t'(POLY), K);

  // one reduction-XOR tree per output bit, masked by its matrix row
  generate
    for (genvar i = 0; i < N; i++) begin : g_row
      localparam logic [N-1:0] ROW = MK[i][N-1:0];
      assign y_o[i] = ^(x_i & ROW);
    end
  endgenerate
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int           N    = 32,
  parameter logic [N-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_init,
  input  logic         ev_byte,
  input  logic         ev_wide,
  input  logic [N-1:0] nxt_byte_i,
  input  logic [N-1:0] nxt_wide_i,
  output logic [N-1:0] state_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= INIT;
    end else if (ev_init) begin
      state_o <= INIT;
    end else if (ev_wide) begin
      state_o <= nxt_wide_i;
    end else if (ev_byte) begin
      state_o <= nxt_byte_i;
    end
  end
endmodule

// File: rtl/crc_par_engine.sv
module crc_par_engine #(
  parameter int           N    = 32,
  parameter logic [N-1:0] POLY = 32'h04C1_1DB7,
  parameter logic [N-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         valid_i,
  input  logic         wide_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] crc_o
);
  localparam int BYTE_W = 8;

  logic [N-1:0] state;
  logic [N-1:0] x_byte;
  logic [N-1:0] x_wide;
  logic [N-1:0] nxt_byte;
  logic [N-1:0] nxt_wide;

  // named update events, visible to the checker
  logic ev_init;
  logic ev_byte;
  logic ev_wide;

  assign ev_init = init_i;
  assign ev_byte = valid_i & ~wide_i & ~init_i;
  assign ev_wide = valid_i &  wide_i & ~init_i;

  crc_data_align #(.N(N), .BYTE_W(BYTE_W)) u_align (
    .state_i (state),
    .data_i  (data_i),
    .x_byte_o(x_byte),
    .x_wide_o(x_wide)
  );

  crc_xor_net #(.N(N), .POLY(POLY), .K(BYTE_W)) u_net_byte (
    .x_i(x_byte),
    .y_o(nxt_byte)
  );

  crc_xor_net #(.N(N), .POLY(POLY), .K(N)) u_net_wide (
    .x_i(x_wide),
    .y_o(nxt_wide)
  );

  crc_state_reg #(.N(N), .INIT(INIT)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_init   (ev_init),
    .ev_byte   (ev_byte),
    .ev_wide   (ev_wide),
    .nxt_byte_i(nxt_byte),
    .nxt_wide_i(nxt_wide),
    .state_o   (state)
  );

  assign crc_o = state;
endmodule

// File: rtl/crc_par_engine_chk.sv
module crc_par_engine_chk
  import crc_mat_pkg::*;
#(
  parameter int           N    = 32,
  parameter logic [N-1:0] POLY = 32'h04C1_1DB7,
  parameter logic [N-1:0] INIT = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         init_i,
  input logic         valid_i,
  input logic         wide_i,
  input logic [N-1:0] data_i,
  input logic [N-1:0] crc_o,
  input logic         ev_byte,
  input logic         ev_wide
);
  logic [N-1:0] ser_byte;
  logic [N-1:0] ser_wide;
  logic [N-1:0] byte_word;

  assign byte_word = {data_i[7:0], {(N-8){1'b0}}};
  assign ser_byte  = N'(serial_adv(N, vec_t'(POLY), vec_t'(crc_o ^ byte_word), 8));
  assign ser_wide  = N'(serial_adv(N, vec_t'(POLY), vec_t'(crc_o ^ data_i), N));

  p_init_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> crc_o == INIT);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !valid_i) |=> $stable(crc_o));

  p_byte_serial_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> crc_o == $past(ser_byte));

  p_wide_serial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wide |=> crc_o == $past(ser_wide));

  p_zero_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !init_i && crc_o == '0 && data_i == '0) |=> crc_o == '0);
endmodule

bind crc_par_engine crc_par_engine_chk #(.N(N), .POLY(POLY), .INIT(INIT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .init_i (init_i),
  .valid_i(valid_i),
  .wide_i (wide_i),
  .data_i (data_i),
  .crc_o  (crc_o),
  .ev_byte(ev_byte),
  .ev_wide(ev_wide)
);

// File: tb/crc_par_engine_bench.sv
module crc_par_engine_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 32;
  localparam logic [31:0] POLY       = 32'h04C1_1DB7;
  localparam logic [31:0] INIT       = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic        valid_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] crc_o;

  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [31:0] exp_crc;
  logic [31:0] saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_par_engine u_crc_par_engine (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .valid_i(valid_i),
    .wide_i(wide_i), .data_i(data_i), .crc_o(crc_o)
  );

  // bit-at-a-time model: shift left, fold the polynomial in on a 1 leaving the top
  function automatic logic [31:0] bit_shift(input logic [31:0] v, input int k);
    logic [31:0] s;
    s = v;
    for (int t = 0; t < k; t++) begin
      if (s[31]) s = {s[30:0], 1'b0} ^ POLY;
      else       s = {s[30:0], 1'b0};
    end
    return s;
  endfunction

  function automatic logic [31:0] model_next(input logic [31:0] cur, input logic ini,
                                             input logic val, input logic wd,
                                             input logic [31:0] d);
    if (ini)      return INIT;
    else if (!val) return cur;
    else if (wd)  return bit_shift(cur ^ d, 32);
    else          return bit_shift(cur ^ {d[7:0], 24'h0}, 8);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: crc_o=%08h expected %08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic ini, input logic val, input logic wd,
                       input logic [31:0] d, input string req);
    @(negedge clk);
    init_i = ini; valid_i = val; wide_i = wd; data_i = d;
    exp_crc = model_next(exp_crc, ini, val, wd, d);
    @(posedge clk);
    #1;
    check(crc_o, exp_crc, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: crc_o=%08h expected run to finish", crc_o);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20250611));
    exp_crc = INIT;
    repeat (3) @(posedge clk);
    #1;
    check(crc_o, INIT, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(crc_o, INIT, "R1 after release");

    // R5 known check value for bytes "123456789"
    for (int i = 0; i < 9; i++) drive(1'b0, 1'b1, 1'b0, 32'h31 + i, "R5 check string");
    check(crc_o, 32'h0376_E6E7, "R5 check value");

    // R4 hold with random data and mode
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, i[0], $urandom, "R4 hold");

    // R3 init wins over valid
    drive(1'b1, 1'b1, 1'b1, $urandom, "R3 init over valid");

    // R5 random byte steps
    for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, 1'b0, $urandom, "R5 random byte");
    // R6 random word steps
    for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, 1'b1, $urandom, "R6 random word");
    // mixed modes, occasional idle and init
    for (int i = 0; i < 120; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0)      drive(1'b1, $urandom_range(0, 1) == 1, 1'b0, $urandom, "R3 random init");
      else if (r == 1) drive(1'b0, 1'b0, 1'b1, $urandom, "R4 random idle");
      else if (r < 6)  drive(1'b0, 1'b1, 1'b0, $urandom, "R5 mixed byte");
      else             drive(1'b0, 1'b1, 1'b1, $urandom, "R6 mixed word");
    end

    // R5 all-zero message from the preset
    drive(1'b1, 1'b0, 1'b0, '0, "R3 restart");
    for (int i = 0; i < 16; i++) drive(1'b0, 1'b1, 1'b0, '0, "R5 zero message");

    // R7 upper data bits ignored in byte mode
    drive(1'b1, 1'b0, 1'b0, '0, "R3 restart");
    drive(1'b0, 1'b1, 1'b0, 32'h0000_005A, "R7 clean byte");
    saved = crc_o;
    drive(1'b1, 1'b0, 1'b0, '0, "R3 restart");
    drive(1'b0, 1'b1, 1'b0, 32'hDEAD_BE5A, "R7 dirty byte");
    check(crc_o, saved, "R7 upper bits no effect");

    // R8 four bytes equal one word
    for (int rep = 0; rep < 4; rep++) begin
      w = $urandom;
      drive(1'b1, 1'b0, 1'b0, '0, "R3 restart");
      drive(1'b0, 1'b1, 1'b0, {24'h0, w[31:24]}, "R8 byte 3");
      drive(1'b0, 1'b1, 1'b0, {24'h0, w[23:16]}, "R8 byte 2");
      drive(1'b0, 1'b1, 1'b0, {24'h0, w[15:8]},  "R8 byte 1");
      drive(1'b0, 1'b1, 1'b0, {24'h0, w[7:0]},   "R8 byte 0");
      saved = crc_o;
      drive(1'b1, 1'b0, 1'b0, '0, "R3 restart");
      drive(1'b0, 1'b1, 1'b1, w, "R8 word");
      check(crc_o, saved, "R8 bytes equal word");
    end

    // R2 single-bit message: state XOR data leaves only bit 31 set
    drive(1'b1, 1'b0, 1'b0, '0, "R3 restart");
    drive(1'b0, 1'b1, 1'b1, INIT ^ 32'h8000_0000, "R2 single bit word");
    check(crc_o, bit_shift(32'h8000_0000, 32), "R2 single bit value");
    drive(1'b1, 1'b0, 1'b0, '0, "R3 restart");
    drive(1'b0, 1'b1, 1'b1, INIT ^ 32'h0000_0001, "R2 low bit word");
    check(crc_o, 32'h04C1_1DB7, "R2 low bit reaches top once");

    // R9 zero state stays zero
    drive(1'b0, 1'b1, 1'b1, crc_o, "R9 cancel to zero");
    check(crc_o, 32'h0, "R9 zero reached");
    drive(1'b0, 1'b1, 1'b1, '0, "R9 zero word");
    drive(1'b0, 1'b1, 1'b0, '0, "R9 zero byte");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule